// File: doc/BRIEF.md
# Butterfly Self-Routing Switch Network

This block is a pipelined butterfly interconnect for `2^K` columns. In each cycle, every column at the entry rank may carry one packet. A packet has a valid flag, a `K`-bit destination column and a `W`-bit payload. The packet then passes through `K` registered stages of 2x2 switches.

At each stage the switch looks at one destination bit, taking them from the most significant bit downward. It writes that bit into the matching position of the packet's current column. The wiring between stages only ever changes that single column bit, so the network needs no routing tables. After the last stage, the column a packet occupies equals its destination.

Two valid packets at one switch can ask for the same output. When that happens, the packet from the lower column goes on and the other one is discarded. The discard is reported on a one-cycle blocked flag, indexed by the column where the lost packet originally entered the network. A new set of packets may be offered in every cycle.

Top module: `bfly_route_net`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every bit of `out_valid` and `blk_pulse` is 0.
- R2: A valid packet offered at entry column j appears exactly K clock edges later on output column `dst`, with its payload unchanged. Column j's destination occupies `in_dest[j*K +: K]` and its payload occupies `in_data[j*W +: W]`. The same field layout applies to `out_data`.
- R3: Every permutation of the form `dst = j XOR c`, with all columns valid at once, is delivered in full with no packet discarded.
- R4: Stage s (s = 0 to K-1) replaces bit K-1-s of the current column with bit K-1-s of the destination. With K=3, a packet entering at column 2 with destination 101 leaves on column 5.
- R5: When two valid packets at one stage need the same output column, the packet currently in the lower column continues. The other packet never reaches any output.
- R6: A packet discarded at stage s raises `blk_pulse[j]` for one cycle, s+1 clock edges after it was offered, where j is its entry column. Apart from this, `blk_pulse` stays 0.
- R7: An entry slot whose valid bit is 0 produces no output and no blocked flag, whatever its destination and payload bits hold, and it does not disturb valid packets.
- R8: A fresh set of packets is accepted in every cycle, and sets offered on consecutive cycles emerge on consecutive cycles without affecting one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2^K | Packet present, one bit per entry column |
| in_dest | input | 2^K*K | Destination column per entry column |
| in_data | input | 2^K*W | Payload per entry column |
| out_valid | output | 2^K | Packet present, one bit per exit column |
| out_data | output | 2^K*W | Payload per exit column |
| blk_pulse | output | 2^K | Discard flag, indexed by entry column |

## Verification
The bench builds the network with K=3 and W=8, which gives 8 columns and 3 stages. At that size the bench can enumerate all 64 single-packet source and destination pairs and all 8 XOR permutations. Directed pairs of packets force a collision at each of the three stages in turn, so the lower-column priority and the timing of the blocked flag are checked at every depth. A run of random, partly valid sets then checks stage overlap and discards of several packets in the same cycle.

// File: rtl/bfly_route_net.sv
module bfly_route_net #(
  parameter int K = 3,
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [(1<<K)-1:0]     in_valid,
  input  logic [(1<<K)*K-1:0]   in_dest,
  input  logic [(1<<K)*W-1:0]   in_data,
  output logic [(1<<K)-1:0]     out_valid,
  output logic [(1<<K)*W-1:0]   out_data,
  output logic [(1<<K)-1:0]     blk_pulse
);
  localparam int N = 1 << K;

  logic           vld [K+1][N];
  logic [K-1:0]   dst [K+1][N];
  logic [K-1:0]   org [K+1][N];
  logic [W-1:0]   pay [K+1][N];

  logic           nv  [K][N];
  logic [K-1:0]   nd  [K][N];
  logic [K-1:0]   no  [K][N];
  logic [W-1:0]   np  [K][N];
  logic           lost[K][N];

  logic [N-1:0]   blk_n;

  for (genvar j = 0; j < N; j++) begin : g_entry
    assign vld[0][j] = in_valid[j];
    assign dst[0][j] = in_dest[j*K +: K];
    assign org[0][j] = K'(j);
    assign pay[0][j] = in_data[j*W +: W];
    assign out_valid[j]       = vld[K][j];
    assign out_data[j*W +: W] = pay[K][j];
  end

  for (genvar s = 0; s < K; s++) begin : g_stage
    localparam int B = K - 1 - s;
    for (genvar p = 0; p < N/2; p++) begin : g_sw
      localparam int LO = ((p >> B) << (B + 1)) | (p & ((1 << B) - 1));
      localparam int HI = LO | (1 << B);
      logic a_up, b_up, lo_a, hi_a;
      assign a_up = dst[s][LO][B];
      assign b_up = dst[s][HI][B];
      assign lo_a = vld[s][LO] & ~a_up;
      assign hi_a = vld[s][LO] &  a_up;

      assign nv[s][LO] = lo_a | (vld[s][HI] & ~b_up);
      assign nv[s][HI] = hi_a | (vld[s][HI] &  b_up);
      assign nd[s][LO] = lo_a ? dst[s][LO] : dst[s][HI];
      assign nd[s][HI] = hi_a ? dst[s][LO] : dst[s][HI];
      assign no[s][LO] = lo_a ? org[s][LO] : org[s][HI];
      assign no[s][HI] = hi_a ? org[s][LO] : org[s][HI];
      assign np[s][LO] = lo_a ? pay[s][LO] : pay[s][HI];
      assign np[s][HI] = hi_a ? pay[s][LO] : pay[s][HI];

      assign lost[s][LO] = 1'b0;
      assign lost[s][HI] = vld[s][LO] & vld[s][HI] & (a_up == b_up);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < K; s++)
      for (int j = 0; j < N; j++)
        vld[s+1][j] <= rst_n ? nv[s][j] : 1'b0;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < K; s++)
      for (int j = 0; j < N; j++) begin
        dst[s+1][j] <= nd[s][j];
        org[s+1][j] <= no[s][j];
        pay[s+1][j] <= np[s][j];
      end
  end

  always_comb begin
    blk_n = '0;
    for (int s = 0; s < K; s++)
      for (int j = 0; j < N; j++)
        if (lost[s][j]) blk_n[org[s][j]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) blk_pulse <= '0;
    else        blk_pulse <= blk_n;
  end
endmodule

// File: rtl/bfly_route_net_chk.sv
module bfly_route_net_chk #(
  parameter int K = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [(1<<K)-1:0]  in_valid,
  input logic [(1<<K)-1:0]  out_valid,
  input logic [(1<<K)-1:0]  blk_pulse
);
  localparam int N  = 1 << K;
  localparam int CW = K + 1;

  logic           any_h [K];
  logic [CW-1:0]  cnt_h [K];
  logic [N-1:0]   col_h [K];
  logic [N-1:0]   col_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < K; i++) begin
        any_h[i] <= 1'b0;
        cnt_h[i] <= '0;
        col_h[i] <= '0;
      end
    end else begin
      any_h[0] <= |in_valid;
      cnt_h[0] <= CW'($countones(in_valid));
      col_h[0] <= in_valid;
      for (int i = 1; i < K; i++) begin
        any_h[i] <= any_h[i-1];
        cnt_h[i] <= cnt_h[i-1];
        col_h[i] <= col_h[i-1];
      end
    end
  end

  always_comb begin
    col_any = '0;
    for (int i = 0; i < K; i++) col_any = col_any | col_h[i];
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (out_valid == '0 && blk_pulse == '0));

  assert_exit_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != '0) |-> any_h[K-1]);

  assert_no_gain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) <= int'(cnt_h[K-1]));

  assert_blk_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_pulse != '0) |-> ((blk_pulse & ~col_any) == '0));
endmodule

bind bfly_route_net bfly_route_net_chk #(.K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .out_valid(out_valid), .blk_pulse(blk_pulse)
);

// File: tb/bfly_route_net_test.sv
`timescale 1ns/1ps
module bfly_route_net_test;
  localparam int K = 3;
  localparam int W = 8;
  localparam int N = 1 << K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0;
  logic [N*K-1:0] in_dest = '0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0]   out_valid;
  logic [N*W-1:0] out_data;
  logic [N-1:0]   blk_pulse;

  always #4 clk = ~clk;

  bfly_route_net #(.K(K), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .blk_pulse(blk_pulse)
  );

  typedef struct {
    int             due;
    logic [N-1:0]   v;
    logic [N*W-1:0] d;
    string          tag;
  } item_t;

  item_t        q[$];
  logic [N-1:0] exp_blk [int];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  bit run = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic drive(input logic [N-1:0] v, input logic [N*K-1:0] dv,
                       input logic [N*W-1:0] dp, input string tag);
    logic           cv [N];
    logic [K-1:0]   cd [N];
    int             cs [N];
    logic [W-1:0]   cp [N];
    logic           xv [N];
    logic [K-1:0]   xd [N];
    int             xs [N];
    logic [W-1:0]   xp [N];
    item_t          it;
    int             c;
    @(negedge clk);
    in_valid = v; in_dest = dv; in_data = dp;
    c = cyc;
    for (int j = 0; j < N; j++) begin
      cv[j] = v[j]; cd[j] = dv[j*K +: K]; cs[j] = j; cp[j] = dp[j*W +: W];
    end
    for (int s = 0; s < K; s++) begin
      int b;
      b = K - 1 - s;
      for (int j = 0; j < N; j++) xv[j] = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (cv[j]) begin
          int o;
          o = cd[j][b] ? (j | (1 << b)) : (j & ~(1 << b));
          if (!xv[o]) begin
            xv[o] = 1'b1; xd[o] = cd[j]; xs[o] = cs[j]; xp[o] = cp[j];
          end else begin
            logic [N-1:0] m;
            m = '0; m[cs[j]] = 1'b1;
            if (exp_blk.exists(c + s + 1)) exp_blk[c + s + 1] |= m;
            else exp_blk[c + s + 1] = m;
          end
        end
      end
      for (int j = 0; j < N; j++) begin
        cv[j] = xv[j]; cd[j] = xd[j]; cs[j] = xs[j]; cp[j] = xp[j];
      end
    end
    it.due = c + K; it.v = '0; it.d = '0; it.tag = tag;
    for (int j = 0; j < N; j++) if (cv[j]) begin
      it.v[j] = 1'b1; it.d[j*W +: W] = cp[j];
    end
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      drive('0, (N*K)'({$urandom, $urandom}), (N*W)'({$urandom, $urandom}), "R7");
  endtask

  initial begin : monitor
    item_t        it;
    logic [N-1:0] ev, eb;
    logic [N*W-1:0] ed;
    string        t;
    bit           bad;
    wait (run);
    forever begin
      @(negedge clk);
      ev = '0; ed = '0; t = "R7";
      if (q.size() > 0 && q[0].due == cyc) begin
        it = q.pop_front(); ev = it.v; ed = it.d; t = it.tag;
      end
      bad = (out_valid !== ev);
      for (int j = 0; j < N; j++)
        if (ev[j] && out_data[j*W +: W] !== ed[j*W +: W]) bad = 1'b1;
      compared++;
      if (bad) begin
        mismatched++;
        $display("FAIL %s cyc=%0d out_valid=%b exp=%b out_data=%h exp=%h",
                 t, cyc, out_valid, ev, out_data, ed);
      end
      eb = exp_blk.exists(cyc) ? exp_blk[cyc] : '0;
      compared++;
      if (blk_pulse !== eb) begin
        mismatched++;
        $display("FAIL R6 cyc=%0d blk_pulse=%b exp=%b", cyc, blk_pulse, eb);
      end
    end
  end

  function automatic logic [N*K-1:0] put_d(input logic [N*K-1:0] v, input int j, input int d);
    v[j*K +: K] = K'(d);
    return v;
  endfunction

  function automatic logic [N*W-1:0] put_p(input logic [N*W-1:0] v, input int j, input int d);
    v[j*W +: W] = W'(d);
    return v;
  endfunction

  initial begin : main
    logic [N*K-1:0] dv;
    logic [N*W-1:0] dp;
    repeat (3) @(posedge clk);
    compared++;
    if (out_valid !== '0 || blk_pulse !== '0) begin
      mismatched++;
      $display("FAIL R1 in reset out_valid=%b blk_pulse=%b exp=0", out_valid, blk_pulse);
    end
    @(negedge clk);
    rst_n = 1'b1;
    compared++;
    if (out_valid !== '0 || blk_pulse !== '0) begin
      mismatched++;
      $display("FAIL R1 after release out_valid=%b blk_pulse=%b exp=0", out_valid, blk_pulse);
    end
    run = 1;

    // R4: column 2 to destination 5
    drive(8'b0000_0100, put_d('0, 2, 5), put_p('0, 2, 8'hA5), "R4");
    idle(K + 1);

    // R2: every source to every destination, back to back
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        logic [N-1:0] v;
        v = '0; v[s] = 1'b1;
        drive(v, put_d('0, s, d), put_p('0, s, s*16 + d), "R2");
      end
    idle(2);

    // R3: xor permutations with all columns loaded
    for (int c = 0; c < N; c++) begin
      dv = '0; dp = '0;
      for (int j = 0; j < N; j++) begin
        dv = put_d(dv, j, j ^ c);
        dp = put_p(dp, j, c*16 + j);
      end
      drive('1, dv, dp, "R3");
    end
    idle(2);

    // R5/R6: collisions at stage 0, 1 and 2
    drive(8'b0001_0001, put_d(put_d('0, 0, 0), 4, 1), put_p(put_p('0, 0, 8'h11), 4, 8'h44), "R5");
    idle(1);
    drive(8'b0000_0101, put_d(put_d('0, 0, 0), 2, 1), put_p(put_p('0, 0, 8'h21), 2, 8'h22), "R5");
    idle(1);
    drive(8'b0000_0011, put_d(put_d('0, 0, 2), 1, 2), put_p(put_p('0, 0, 8'h31), 1, 8'h32), "R5");
    idle(1);

    // R7: an invalid slot holding a colliding destination has no effect
    drive(8'b0000_1000, put_d(put_d('0, 3, 6), 7, 6), put_p(put_p('0, 3, 8'h3C), 7, 8'hFF), "R7");
    idle(K + 1);

    // R8: random partly valid sets every cycle
    for (int i = 0; i < 60; i++)
      drive(N'($urandom), (N*K)'({$urandom, $urandom}), (N*W)'({$urandom, $urandom}), "R8");
    idle(K + 2);

    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired, pending=%0d expected=0", q.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule